// File: doc/BRIEF.md
# Host Bridge Configuration Responder

This block answers configuration cycles that a host issues over a byte-addressed I/O port bus. It holds a 32-bit address latch on one port and a four-byte data window on four neighbouring ports. When the latched address selects bus 0, device 0, function 0 with the enable bit set, window accesses reach a private 256-byte configuration register file. Any other selection reads back as all ones, and writes to it are dropped.

Reads and writes through the window can be 1, 2 or 4 bytes wide. Writes are clipped at the end of the four-byte window. They are also filtered byte by byte against a fixed set of read-only offsets, which carry identity values. The other bytes reset to defined defaults. A read result appears on the cycle after the request.

Top module: `cfg_bridge`

## Requirements
- R1: The address latch (port 0xCF8) changes only on a 4-byte write to that port, and byte or word writes to it are ignored. A 4-byte read of 0xCF8 returns the latch, which resets to 0. A 1- or 2-byte read of 0xCF8 returns 0xFFFFFFFF.
- R2: The window (ports 0xCFC..0xCFF) reaches the register file only when (latch AND 0x80FFFF00) equals 0x80000000, that is, enable bit 31 is set and bus bits 23:16, device bits 15:11 and function bits 10:8 are all zero. The dword index is taken from latch bits 7:2.
- R3: While the latch does not match, any window read returns 0xFFFFFFFF and any window write changes no register.
- R4: A matching read returns the selected dword shifted right by 8*(port AND 3), masked to 8, 16 or 32 bits for size 1, 2 or 4.
- R5: A matching write starts at byte (latch AND 0xFC)+(port AND 3) and writes min(size, 4-(port AND 3)) bytes, taking write-data byte k for the k-th byte written.
- R6: Bytes 0x00..0x03, 0x06 and 0x08..0x0B are read-only. Writes to them are discarded, while the other bytes of the same access are still written.
- R7: Identity bytes: 0x00..0x03 read 0x86, 0x80, 0x37, 0x12, so dword 0 reads 0x12378086. Byte 0x0B reads 0x06.
- R8: Reset values: dword 0x04 = 0x02800006, dword 0x50 = 0x80000100, dword 0x54 = 0x01000000, dword 0x58 = 0x00000010. Every other writable byte resets to 0.
- R9: io_claim is high exactly for port 0xCF8 and ports 0xCFC..0xCFF. rd_valid pulses on the cycle after each claimed read and on no other cycle. Unclaimed ports change no state.
- R10: A read after a write returns the newly written data, except for the read-only bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Access request strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| io_wdata | input | 32 | Write data, least significant byte first |
| io_claim | output | 1 | Port belongs to this block (combinational) |
| rd_valid | output | 1 | Read result valid, one cycle after request |
| rd_data | output | 32 | Read result |

## Verification
The assertions assume that io_size carries only the values 1, 2 or 4. They also assume that each request is a one-cycle strobe whose port and data are stable during that cycle. The directed tasks keep to this: they raise io_valid for a single cycle with a legal size, and they return it low before the next request. The read-response properties sample the request inputs and the latch in the cycle before rd_valid. This holds because the stimulus never changes the latch in the same cycle as a read.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam int unsigned CFG_BYTES = 256;
  localparam logic [31:0] HIT_MASK  = 32'h80FF_FF00;
  localparam logic [31:0] HIT_VALUE = 32'h8000_0000;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

  // Access size in bytes from the size field; illegal codes act as 4.
  function automatic logic [2:0] size_bytes(input logic [2:0] sz);
    case (sz)
      3'd1:    size_bytes = 3'd1;
      3'd2:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    case (size_bytes(sz))
      3'd1:    size_mask = 32'h0000_00FF;
      3'd2:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Bytes written, clipped at the end of the four-byte window.
  function automatic logic [2:0] write_count(input logic [1:0] off, input logic [2:0] sz);
    logic [2:0] room;
    room = 3'd4 - {1'b0, off};
    write_count = (size_bytes(sz) < room) ? size_bytes(sz) : room;
  endfunction

  function automatic logic cfg_hit(input logic [31:0] addr);
    cfg_hit = ((addr & HIT_MASK) == HIT_VALUE);
  endfunction

  function automatic logic byte_is_ro(input int unsigned idx);
    byte_is_ro = (idx <= 3) || (idx == 6) || (idx >= 8 && idx <= 11);
  endfunction

  function automatic logic [7:0] byte_reset(input int unsigned idx);
    case (idx)
      0:       byte_reset = 8'h86;
      1:       byte_reset = 8'h80;
      2:       byte_reset = 8'h37;
      3:       byte_reset = 8'h12;
      4:       byte_reset = 8'h06;
      6:       byte_reset = 8'h80;
      7:       byte_reset = 8'h02;
      11:      byte_reset = 8'h06;
      'h51:    byte_reset = 8'h01;
      'h53:    byte_reset = 8'h80;
      'h57:    byte_reset = 8'h01;
      'h58:    byte_reset = 8'h10;
      default: byte_reset = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgb_port_decode.sv
module cfgb_port_decode #(
  parameter int unsigned  PORT_W    = 16,
  parameter logic [15:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [15:0]  DATA_PORT = 16'h0CFC
) (
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [PORT_W-1:0] io_port,
  input  logic [2:0]        io_size,
  output logic              claim,
  output logic              sel_addr,
  output logic              sel_win,
  output logic [1:0]        lane,
  output logic              lat_we,
  output logic              win_we,
  output logic              rd_req
);
  localparam logic [PORT_W-1:0] APORT = PORT_W'(ADDR_PORT);
  localparam logic [PORT_W-1:0] DBASE = PORT_W'(DATA_PORT);

  always_comb begin
    sel_addr = (io_port == APORT);
    sel_win  = (io_port[PORT_W-1:2] == DBASE[PORT_W-1:2]);
    lane     = io_port[1:0];
    claim    = sel_addr || sel_win;
    lat_we   = io_valid && io_write && sel_addr && (io_size == 3'd4);
    win_we   = io_valid && io_write && sel_win;
    rd_req   = io_valid && !io_write && claim;
  end
endmodule

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (we) addr_q <= wdata;
  end
endmodule

// File: rtl/cfgb_regfile.sv
module cfgb_regfile
  import cfgb_pkg::*;
#(
  parameter int unsigned NUM_BYTES = CFG_BYTES,
  localparam int unsigned DW_W     = $clog2(NUM_BYTES) - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW_W-1:0] dw_idx,
  input  logic [1:0]      off,
  input  logic [2:0]      sz,
  input  logic [31:0]     wdata,
  output logic [31:0]     rd_dword
);
  logic [7:0] bytes_q [NUM_BYTES];
  logic [3:0] lane_en;
  logic [7:0] lane_data [4];
  logic [2:0] cnt;

  assign cnt = write_count(off, sz);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [1:0] rel;
    logic [2:0] ln;
    assign ln  = 3'(l);
    assign rel = 2'(l) - off;
    assign lane_en[l]   = we && (2'(l) >= off) && (ln < ({1'b0, off} + cnt));
    assign lane_data[l] = wdata[{rel, 3'b000} +: 8];
    assign rd_dword[8*l +: 8] = bytes_q[{dw_idx, 2'(l)}];
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    if (byte_is_ro(b)) begin : g_ro
      assign bytes_q[b] = byte_reset(b);
    end else begin : g_rw
      logic hit_dw;
      assign hit_dw = (dw_idx == DW_W'(b / 4));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      bytes_q[b] <= byte_reset(b);
        else if (hit_dw && lane_en[b % 4]) bytes_q[b] <= lane_data[b % 4];
      end
    end
  end
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int unsigned NUM_BYTES = CFG_BYTES,
  localparam int unsigned DW_W     = $clog2(NUM_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [PORT_W-1:0] io_port,
  input  logic [2:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_claim,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  logic        sel_addr, sel_win, lat_we, win_we, rd_req, cfg_match, cfg_we;
  logic [1:0]  lane;
  logic [31:0] addr_q, rd_dword, rd_next;

  cfgb_port_decode #(.PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .io_valid(io_valid), .io_write(io_write), .io_port(io_port), .io_size(io_size),
    .claim(io_claim), .sel_addr(sel_addr), .sel_win(sel_win), .lane(lane),
    .lat_we(lat_we), .win_we(win_we), .rd_req(rd_req)
  );

  cfgb_addr_latch u_lat (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .wdata(io_wdata), .addr_q(addr_q)
  );

  assign cfg_match = cfg_hit(addr_q);
  assign cfg_we    = win_we && cfg_match;

  cfgb_regfile #(.NUM_BYTES(NUM_BYTES)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .dw_idx(addr_q[DW_W+1:2]),
    .off(lane), .sz(io_size), .wdata(io_wdata), .rd_dword(rd_dword)
  );

  always_comb begin
    if (sel_addr)       rd_next = (io_size == 3'd4) ? addr_q : ALL_ONES;
    else if (cfg_match) rd_next = (rd_dword >> {lane, 3'b000}) & size_mask(io_size);
    else                rd_next = ALL_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_bridge_chk.sv
module cfg_bridge_chk #(
  parameter int unsigned PORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_valid,
  input logic              io_write,
  input logic [PORT_W-1:0] io_port,
  input logic [2:0]        io_size,
  input logic [31:0]       io_wdata,
  input logic              io_claim,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [31:0]       addr_q
);
  logic is_win, is_lat, hit;
  assign is_lat = (io_port == PORT_W'(16'h0CF8));
  assign is_win = (io_port[PORT_W-1:2] == PORT_W'(16'h0CFC) >> 2);
  assign hit    = ((addr_q & 32'h80FF_FF00) == 32'h8000_0000);

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && io_write && is_lat && io_size == 3'd4) |=> $stable(addr_q));

  assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && is_lat && io_size == 3'd4) |=> addr_q == $past(io_wdata));

  assert_miss_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && is_win && !hit) |=> rd_data == 32'hFFFF_FFFF);

  assert_byte_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && is_win && hit && io_size == 3'd1) |=> rd_data[31:8] == 24'h0);

  assert_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_port == PORT_W'(16'h0CFC) && io_size == 3'd4 &&
     addr_q == 32'h8000_0000) |=> rd_data == 32'h1237_8086);

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && (is_win || is_lat)) |=> rd_valid);

  assert_no_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && !io_write && io_claim) |=> !rd_valid);

  assert_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim == (is_win || is_lat));
endmodule

bind cfg_bridge cfg_bridge_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
  .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata), .io_claim(io_claim),
  .rd_valid(rd_valid), .rd_data(rd_data), .addr_q(addr_q)
);

// File: tb/cfg_bridge_test.sv
module cfg_bridge_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_port = '0;
  logic [2:0]  io_size = 3'd4;
  logic [31:0] io_wdata = '0;
  logic        io_claim, rd_valid;
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bridge uut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] port, input logic [2:0] sz,
                        input logic [31:0] d, output logic [31:0] q, output logic vld,
                        output logic clm);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_port = port; io_size = sz; io_wdata = d;
    #1 clm = io_claim;
    @(negedge clk);
    io_valid = 1'b0;
    q = rd_data; vld = rd_valid;
  endtask

  task automatic wr(input logic [15:0] port, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] q; logic v, c;
    access(1'b1, port, sz, d, q, v, c);
    check("R9 no rd_valid after write", {31'b0, v}, 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] port, input logic [2:0] sz,
                        input logic [31:0] exp);
    logic [31:0] q; logic v, c;
    access(1'b0, port, sz, 32'h0, q, v, c);
    check("R9 rd_valid", {31'b0, v}, 32'd1);
    check(req, q, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 latch reset", 16'h0CF8, 3'd4, 32'h0);
    wr(16'h0CF8, 3'd4, 32'h8000_0000);
    rd_chk("R1 latch readback", 16'h0CF8, 3'd4, 32'h8000_0000);
    rd_chk("R7 identity dword", 16'h0CFC, 3'd4, 32'h1237_8086);
    rd_chk("R7 identity byte 3", 16'h0CFF, 3'd1, 32'h12);
    wr(16'h0CF8, 3'd4, 32'h8000_0008);
    rd_chk("R7 byte 0x0B", 16'h0CFC, 3'd4, 32'h0600_0000);
    wr(16'h0CF8, 3'd4, 32'h8000_0004);
    rd_chk("R8 dword 04", 16'h0CFC, 3'd4, 32'h0280_0006);
    wr(16'h0CF8, 3'd4, 32'h8000_0050);
    rd_chk("R8 dword 50", 16'h0CFC, 3'd4, 32'h8000_0100);
    wr(16'h0CF8, 3'd4, 32'h8000_0054);
    rd_chk("R8 dword 54", 16'h0CFC, 3'd4, 32'h0100_0000);
    wr(16'h0CF8, 3'd4, 32'h8000_0058);
    rd_chk("R8 dword 58", 16'h0CFC, 3'd4, 32'h0000_0010);
    wr(16'h0CF8, 3'd4, 32'h8000_000C);
    rd_chk("R8 dword 0C", 16'h0CFC, 3'd4, 32'h0);
  endtask

  task automatic t_latch;
    wr(16'h0CF8, 3'd4, 32'h8000_0010);
    wr(16'h0CF8, 3'd2, 32'h0000_FFFF);
    rd_chk("R1 word write ignored", 16'h0CF8, 3'd4, 32'h8000_0010);
    wr(16'h0CF8, 3'd1, 32'h0000_00FF);
    rd_chk("R1 byte write ignored", 16'h0CF8, 3'd4, 32'h8000_0010);
    rd_chk("R1 narrow latch read", 16'h0CF8, 3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_subread;
    wr(16'h0CF8, 3'd4, 32'h8000_0004);
    rd_chk("R4 word at lane 1", 16'h0CFD, 3'd2, 32'h0000_8000);
    rd_chk("R4 byte at lane 2", 16'h0CFE, 3'd1, 32'h0000_0080);
    rd_chk("R4 dword at lane 3", 16'h0CFF, 3'd4, 32'h0000_0002);
    rd_chk("R4 dword at lane 2", 16'h0CFE, 3'd4, 32'h0000_0280);
  endtask

  task automatic t_write;
    wr(16'h0CF8, 3'd4, 32'h8000_0010);
    wr(16'h0CFC, 3'd4, 32'h1122_3344);
    rd_chk("R10 dword write", 16'h0CFC, 3'd4, 32'h1122_3344);
    wr(16'h0CFE, 3'd2, 32'h0000_BEEF);
    rd_chk("R5 word at lane 2", 16'h0CFC, 3'd4, 32'hBEEF_3344);
    wr(16'h0CFF, 3'd4, 32'hA5A5_A5A5);
    rd_chk("R5 clipped at lane 3", 16'h0CFC, 3'd4, 32'hA5EF_3344);
    wr(16'h0CFD, 3'd1, 32'h0000_0077);
    rd_chk("R5 byte at lane 1", 16'h0CFC, 3'd4, 32'hA5EF_7744);
  endtask

  task automatic t_readonly;
    wr(16'h0CF8, 3'd4, 32'h8000_0004);
    wr(16'h0CFC, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R6 byte 06 kept, others written", 16'h0CFC, 3'd4, 32'hFF80_FFFF);
    wr(16'h0CF8, 3'd4, 32'h8000_0000);
    wr(16'h0CFC, 3'd4, 32'h0);
    rd_chk("R6 identity unchanged", 16'h0CFC, 3'd4, 32'h1237_8086);
    wr(16'h0CF8, 3'd4, 32'h8000_0008);
    wr(16'h0CFD, 3'd2, 32'hFFFF);
    rd_chk("R6 dword 08 unchanged", 16'h0CFC, 3'd4, 32'h0600_0000);
  endtask

  task automatic t_nomatch;
    wr(16'h0CF8, 3'd4, 32'h8000_0800);
    rd_chk("R2 device 1 misses", 16'h0CFC, 3'd4, 32'hFFFF_FFFF);
    wr(16'h0CF8, 3'd4, 32'h0000_0000);
    rd_chk("R2 enable clear misses", 16'h0CFE, 3'd1, 32'hFFFF_FFFF);
    wr(16'h0CF8, 3'd4, 32'h8000_0100);
    rd_chk("R2 function 1 misses", 16'h0CFC, 3'd2, 32'hFFFF_FFFF);
    wr(16'h0CF8, 3'd4, 32'h8001_0014);
    wr(16'h0CFC, 3'd4, 32'hAABB_CCDD);
    wr(16'h0CF8, 3'd4, 32'h8000_0014);
    rd_chk("R3 miss write dropped", 16'h0CFC, 3'd4, 32'h0);
  endtask

  task automatic t_ports;
    logic [31:0] q; logic v, c;
    access(1'b0, 16'h0CF9, 3'd1, 32'h0, q, v, c);
    check("R9 no claim 0CF9", {31'b0, c}, 32'd0);
    check("R9 no rd_valid 0CF9", {31'b0, v}, 32'd0);
    access(1'b0, 16'h0CFF, 3'd1, 32'h0, q, v, c);
    check("R9 claim 0CFF", {31'b0, c}, 32'd1);
    wr(16'h0CF8, 3'd4, 32'h8000_0018);
    access(1'b1, 16'h0CFB, 3'd4, 32'h1234_5678, q, v, c);
    check("R9 no claim 0CFB", {31'b0, c}, 32'd0);
    rd_chk("R9 unclaimed write no effect", 16'h0CF8, 3'd4, 32'h8000_0018);
    rd_chk("R9 register untouched", 16'h0CFC, 3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid at reset", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_subread();
    t_write();
    t_readonly();
    t_nomatch();
    t_ports();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule